// File: doc/BRIEF.md
# Token Bucket Departure-Time Stamper

This block turns a token-bucket shaper into a rank source for a sorted scheduler. It does not hold packets back. Each packet gets a departure time, and a priority queue further down the line can order packets by that time. The block keeps one bucket: a signed token balance and the time of the last update. When a packet arrives, the balance is refilled for the time that has passed since the last update, up to a configured ceiling. The block then works out how long the packet must wait for the tokens it still lacks, and charges the packet length against the balance.

The bucket may go into debt. When a packet finds too few tokens, its length is still deducted, so the balance falls below zero. Each later packet therefore inherits the debt and gets a later departure time. The fill rate is a power of two tokens per time unit, given as a shift amount, so the wait is a division done as a right shift that rounds up.

The unit accepts one packet per clock. Each departure time appears exactly one cycle after its packet.

Top module: `tbr_rank_unit`

## Requirements
- R1: After reset, `rank_valid` is 0 and `rank_time` is 0. The first packet after reset sees a balance equal to `burst_cap`, whatever the time stamp.
- R2: On a packet, the balance is first refilled to min(balance + elapsed × 2^`rate_shift`, `burst_cap`). Elapsed is (`now_time` − last update time) modulo 2^32. The ceiling is the value of `burst_cap` in that cycle.
- R3: The departure time is `now_time` + ceil((`pkt_len` − refilled balance) / 2^`rate_shift`) when that difference is positive, and `now_time` otherwise. The sum is taken modulo 2^32.
- R4: After the departure time is computed, `pkt_len` is subtracted from the refilled balance. The result may be negative, so back-to-back packets that are over budget get strictly later departure times.
- R5: The balance saturates at −2^31 and does not wrap. Once there, a zero-length packet at the same time stamp gets departure time `now_time` + 2^31.
- R6: Each packet sets the last update time to its `now_time`. This holds across wrap-around of `now_time`.
- R7: `rank_valid` rises in the cycle after each cycle with `pkt_valid` high, and carries that packet's departure time in `rank_time`. A packet is accepted in every cycle, so a run of packets gives a run of ranks.
- R8: In a cycle with `pkt_valid` low, the balance and the last update time do not change, whatever `pkt_len`, `now_time`, `rate_shift` and `burst_cap` are. In the next cycle `rank_valid` is 0 and `rank_time` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pkt_valid | input | 1 | A packet is presented this cycle |
| pkt_len | input | 16 | Packet length in tokens |
| now_time | input | 32 | Current time stamp |
| rate_shift | input | 5 | Fill rate is 2^rate_shift tokens per time unit |
| burst_cap | input | 31 | Upper limit of the token balance (non-negative) |
| rank_valid | output | 1 | `rank_time` holds a new departure time |
| rank_time | output | 32 | Departure time of the packet from the previous cycle |

## Verification
Several patterns drive the main function, and each one separates different mistakes. Widely spaced packets that fall under the burst ceiling show whether the ceiling is applied. Dense runs of large packets at one time stamp show whether debt is carried forward, and the spread between successive ranks shows whether the ceiling rounding is right for shifts above zero. A long run of maximum-length packets drives the balance to its floor, which tells saturation apart from wrap. A jump of `now_time` across its wrap point and idle cycles with noisy inputs show whether elapsed time is counted only from the last real packet. A long random phase is compared every cycle against a behavioural model that uses wide integers.

// File: rtl/tbr_pkg.sv
package tbr_pkg;
  // default geometry of the stamper
  localparam int unsigned DEF_TIME_W  = 32;
  localparam int unsigned DEF_TOK_W   = 32;
  localparam int unsigned DEF_LEN_W   = 16;
  localparam int unsigned DEF_SHIFT_W = 5;
  localparam int unsigned DEF_SYNC_N  = 2;

  // state of the reset release pipeline
  typedef enum logic [0:0] {
    CORE_HELD = 1'b0,
    CORE_RUN  = 1'b1
  } core_state_e;
endpackage

// File: rtl/tbr_refill.sv
module tbr_refill
  import tbr_pkg::*;
#(
  parameter int unsigned TIME_W  = DEF_TIME_W,
  parameter int unsigned TOK_W   = DEF_TOK_W,
  parameter int unsigned SHIFT_W = DEF_SHIFT_W
) (
  input  logic [TIME_W-1:0]       now_time,
  input  logic [TIME_W-1:0]       last_time,
  input  logic [SHIFT_W-1:0]      rate_shift,
  input  logic signed [TOK_W-1:0] tok_cur,
  input  logic [TOK_W-2:0]        burst_cap,
  output logic signed [TOK_W-1:0] tok_ref
);
  // largest refill is elapsed shifted by the biggest shift amount
  localparam int unsigned EXT_W = TIME_W + (1 << SHIFT_W);
  localparam int unsigned SUM_W = ((EXT_W > TOK_W) ? EXT_W : TOK_W) + 2;

  logic [TIME_W-1:0]       elapsed;
  logic [EXT_W-1:0]        gain;
  logic signed [SUM_W-1:0] sum;
  logic signed [SUM_W-1:0] cap;

  always_comb begin
    // modular difference handles time stamp wrap
    elapsed = now_time - last_time;
    gain    = {{(EXT_W-TIME_W){1'b0}}, elapsed} << rate_shift;
    sum     = {{(SUM_W-TOK_W){tok_cur[TOK_W-1]}}, tok_cur}
            + {{(SUM_W-EXT_W){1'b0}}, gain};
    cap     = {{(SUM_W-TOK_W+1){1'b0}}, burst_cap};
    // ceiling only from above: a debt is refilled but never lifted past cap
    tok_ref = (sum > cap) ? TOK_W'(cap) : TOK_W'(sum);
  end
endmodule

// File: rtl/tbr_wait_calc.sv
module tbr_wait_calc
  import tbr_pkg::*;
#(
  parameter int unsigned TIME_W  = DEF_TIME_W,
  parameter int unsigned TOK_W   = DEF_TOK_W,
  parameter int unsigned LEN_W   = DEF_LEN_W,
  parameter int unsigned SHIFT_W = DEF_SHIFT_W
) (
  input  logic [TIME_W-1:0]       now_time,
  input  logic signed [TOK_W-1:0] tok_ref,
  input  logic [LEN_W-1:0]        pkt_len,
  input  logic [SHIFT_W-1:0]      rate_shift,
  output logic                    late,
  output logic [TIME_W-1:0]       send_time
);
  // room for deficit plus rounding bias at the largest shift
  localparam int unsigned W = TOK_W + (1 << SHIFT_W) + 2;

  logic signed [W-1:0] deficit;
  logic [W-1:0]        bias;

  always_comb begin
    deficit = {{(W-LEN_W){1'b0}}, pkt_len}
            - {{(W-TOK_W){tok_ref[TOK_W-1]}}, tok_ref};
    late    = (deficit > 0);
    // adding 2^s - 1 before the shift rounds the quotient up
    bias    = (W'(1) << rate_shift) - W'(1);
    if (late) begin
      send_time = now_time + TIME_W'((W'(deficit) + bias) >> rate_shift);
    end else begin
      send_time = now_time;
    end
  end
endmodule

// File: rtl/tbr_state_regs.sv
module tbr_state_regs
  import tbr_pkg::*;
#(
  parameter int unsigned TIME_W = DEF_TIME_W,
  parameter int unsigned TOK_W  = DEF_TOK_W,
  parameter int unsigned LEN_W  = DEF_LEN_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    pkt_valid,
  input  logic [LEN_W-1:0]        pkt_len,
  input  logic [TIME_W-1:0]       now_time,
  input  logic [TOK_W-2:0]        burst_cap,
  input  logic signed [TOK_W-1:0] tok_ref,
  input  logic [TIME_W-1:0]       send_time,
  output logic signed [TOK_W-1:0] tok_cur,
  output logic [TIME_W-1:0]       last_time,
  output logic                    rank_valid,
  output logic [TIME_W-1:0]       rank_time
);
  localparam int unsigned AW = TOK_W + 1;
  localparam logic signed [AW-1:0] FLOOR = {2'b11, {(TOK_W-1){1'b0}}};

  logic signed [TOK_W-1:0] tok_q, tok_d;
  logic [TIME_W-1:0]       last_q, last_d;
  logic [TIME_W-1:0]       rank_q, rank_d;
  logic                    rv_q, rv_d;
  logic                    fresh_q, fresh_d;
  logic signed [AW-1:0]    after;

  // a fresh bucket reads as full so the reset value needs no input
  assign tok_cur    = fresh_q ? {1'b0, burst_cap} : tok_q;
  assign last_time  = last_q;
  assign rank_valid = rv_q;
  assign rank_time  = rank_q;

  always_comb begin
    after   = {tok_ref[TOK_W-1], tok_ref} - {{(AW-LEN_W){1'b0}}, pkt_len};
    tok_d   = tok_q;
    last_d  = last_q;
    rank_d  = rank_q;
    fresh_d = fresh_q;
    rv_d    = pkt_valid;
    if (pkt_valid) begin
      tok_d   = (after < FLOOR) ? TOK_W'(FLOOR) : TOK_W'(after);
      last_d  = now_time;
      rank_d  = send_time;
      fresh_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tok_q   <= '0;
      last_q  <= '0;
      rank_q  <= '0;
      rv_q    <= 1'b0;
      fresh_q <= 1'b1;
    end else begin
      rv_q <= rv_d;
      if (pkt_valid) begin
        tok_q   <= tok_d;
        last_q  <= last_d;
        rank_q  <= rank_d;
        fresh_q <= fresh_d;
      end
    end
  end

  // R6
  last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid |=> last_q == $past(now_time));

  // R7
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid |=> rv_q && rank_q == $past(send_time));

  // R8
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pkt_valid |=> !rv_q && $stable(tok_q) && $stable(last_q) && $stable(rank_q));

  // R4
  tokens_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid |=> tok_q <= $past(tok_ref));
endmodule

// File: rtl/tbr_rank_unit.sv
module tbr_rank_unit
  import tbr_pkg::*;
#(
  parameter int unsigned TIME_W  = DEF_TIME_W,
  parameter int unsigned TOK_W   = DEF_TOK_W,
  parameter int unsigned LEN_W   = DEF_LEN_W,
  parameter int unsigned SHIFT_W = DEF_SHIFT_W,
  parameter int unsigned SYNC_N  = DEF_SYNC_N
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pkt_valid,
  input  logic [LEN_W-1:0]   pkt_len,
  input  logic [TIME_W-1:0]  now_time,
  input  logic [SHIFT_W-1:0] rate_shift,
  input  logic [TOK_W-2:0]   burst_cap,
  output logic               rank_valid,
  output logic [TIME_W-1:0]  rank_time
);
  logic [SYNC_N-1:0]       rst_pipe;
  logic                    core_rst_n;
  logic signed [TOK_W-1:0] tok_cur;
  logic signed [TOK_W-1:0] tok_ref;
  logic [TIME_W-1:0]       last_time;
  logic [TIME_W-1:0]       send_time;
  logic                    late;

  // reset asserts at once, releases after SYNC_N clock edges
  generate
    if (SYNC_N == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rst_pipe <= '0;
        else        rst_pipe <= 1'b1;
      end
    end else begin : g_syncn
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rst_pipe <= '0;
        else        rst_pipe <= {rst_pipe[SYNC_N-2:0], 1'b1};
      end
    end
  endgenerate

  assign core_rst_n = (rst_pipe[SYNC_N-1] == CORE_RUN);

  tbr_refill #(
    .TIME_W(TIME_W), .TOK_W(TOK_W), .SHIFT_W(SHIFT_W)
  ) u_refill (
    .now_time  (now_time),
    .last_time (last_time),
    .rate_shift(rate_shift),
    .tok_cur   (tok_cur),
    .burst_cap (burst_cap),
    .tok_ref   (tok_ref)
  );

  tbr_wait_calc #(
    .TIME_W(TIME_W), .TOK_W(TOK_W), .LEN_W(LEN_W), .SHIFT_W(SHIFT_W)
  ) u_wait (
    .now_time  (now_time),
    .tok_ref   (tok_ref),
    .pkt_len   (pkt_len),
    .rate_shift(rate_shift),
    .late      (late),
    .send_time (send_time)
  );

  tbr_state_regs #(
    .TIME_W(TIME_W), .TOK_W(TOK_W), .LEN_W(LEN_W)
  ) u_state (
    .clk       (clk),
    .rst_n     (core_rst_n),
    .pkt_valid (pkt_valid),
    .pkt_len   (pkt_len),
    .now_time  (now_time),
    .burst_cap (burst_cap),
    .tok_ref   (tok_ref),
    .send_time (send_time),
    .tok_cur   (tok_cur),
    .last_time (last_time),
    .rank_valid(rank_valid),
    .rank_time (rank_time)
  );

  // R2
  cap_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
    pkt_valid |-> tok_ref <= $signed({1'b0, burst_cap}));

  // R3
  on_time_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
    pkt_valid && !late |=> rank_time == $past(now_time));

  // R3
  delayed_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
    pkt_valid && late |=> rank_time != $past(now_time) || $past(rate_shift) != 0
                          || $past(pkt_len) == 0);
endmodule

// File: tb/sim_tbr_rank_unit.sv
module sim_tbr_rank_unit;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_CYC    = 200000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        pkt_valid;
  logic [15:0] pkt_len;
  logic [31:0] now_time;
  logic [4:0]  rate_shift;
  logic [30:0] burst_cap;
  logic        rank_valid;
  logic [31:0] rank_time;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit done   = 1'b0;
  string cur_req = "R1";

  // behavioural model state
  logic signed [127:0] m_tok;
  bit                  m_fresh;
  logic [31:0]         m_last;
  logic [31:0]         m_rank;
  bit                  m_rv;

  tbr_rank_unit u0 (
    .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid), .pkt_len(pkt_len),
    .now_time(now_time), .rate_shift(rate_shift), .burst_cap(burst_cap),
    .rank_valid(rank_valid), .rank_time(rank_time)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cycles <= cycles + 1;

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    wait (cycles >= MAX_CYC);
    errors++;
    checks++;
    $display("FAIL watchdog (%s): actual cycles=%0d expected < %0d", cur_req, cycles, MAX_CYC);
    finish_run();
  end

  task automatic check_out();
    checks++;
    if (rank_valid !== m_rv) begin
      errors++;
      $display("FAIL %s rank_valid: actual=%0b expected=%0b", cur_req, rank_valid, m_rv);
    end
    checks++;
    if (rank_time !== m_rank) begin
      errors++;
      $display("FAIL %s rank_time: actual=%0d expected=%0d", cur_req, rank_time, m_rank);
    end
  endtask

  task automatic model(input bit v, input logic [15:0] l, input logic [31:0] t,
                       input logic [4:0] sh, input logic [30:0] b);
    logic signed [127:0] cur, s, d, w, cap, pw;
    logic [31:0] el;
    m_rv = v;
    if (v) begin
      cap = $signed({97'b0, b});
      cur = m_fresh ? cap : m_tok;
      el  = t - m_last;
      pw  = 128'sd1 <<< sh;
      s   = cur + $signed({96'b0, el}) * pw;
      if (s > cap) s = cap;
      d = $signed({112'b0, l}) - s;
      w = (d > 0) ? (d + pw - 1) / pw : 128'sd0;
      m_rank = t + w[31:0];
      m_tok  = s - $signed({112'b0, l});
      if (m_tok < -(128'sd1 <<< 31)) m_tok = -(128'sd1 <<< 31);
      m_fresh = 1'b0;
      m_last  = t;
    end
  endtask

  task automatic step(input bit v, input logic [15:0] l, input logic [31:0] t);
    pkt_valid = v;
    pkt_len   = l;
    now_time  = t;
    @(posedge clk);
    #1;
    model(v, l, t, rate_shift, burst_cap);
    check_out();
  endtask

  initial begin
    logic [31:0] t;
    rst_n = 1'b0;
    pkt_valid = 1'b0; pkt_len = '0; now_time = '0;
    rate_shift = '0; burst_cap = 31'd1000;
    m_tok = '0; m_fresh = 1'b1; m_last = '0; m_rank = '0; m_rv = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset outputs
    cur_req = "R1";
    check_out();
    rst_n = 1'b1;
    repeat (3) step(1'b0, 16'd7, 32'd5);

    // R1 first packet sees a full bucket even at a late time stamp
    step(1'b1, 16'd100, 32'd5000);
    // R4 debt builds: 900 -> 0 -> -500, ranks move out
    cur_req = "R4";
    step(1'b1, 16'd900, 32'd5000);
    step(1'b1, 16'd500, 32'd5000);
    step(1'b1, 16'd300, 32'd5000);

    // R8 idle with noisy inputs, then a packet shows no refill from idle stamps
    cur_req = "R8";
    rate_shift = 5'd3;
    burst_cap  = 31'd12;
    step(1'b0, 16'hFFFF, 32'd9000);
    step(1'b0, 16'h1234, 32'd1);
    burst_cap = 31'd1000;
    rate_shift = 5'd0;
    step(1'b1, 16'd0, 32'd5010);

    // R3 rounding up with shift 3
    cur_req = "R3";
    rate_shift = 5'd3;
    step(1'b1, 16'd1000, 32'd5010);
    step(1'b1, 16'd17, 32'd5010);
    step(1'b1, 16'd9, 32'd5011);

    // R2 long gap hits the ceiling, then a lowered ceiling applies at once
    cur_req = "R2";
    step(1'b1, 16'd50, 32'd90000);
    burst_cap = 31'd40;
    step(1'b1, 16'd200, 32'd95000);
    burst_cap = 31'd1000;
    step(1'b1, 16'd10, 32'd95002);

    // R6 time stamp wrap
    cur_req = "R6";
    rate_shift = 5'd0;
    step(1'b1, 16'd2000, 32'hFFFF_FFF0);
    step(1'b1, 16'd10, 32'h0000_0010);
    step(1'b0, 16'd0, 32'h0000_0020);

    // R7 back-to-back run with rising lengths
    cur_req = "R7";
    rate_shift = 5'd1;
    for (int i = 0; i < 20; i++) step(1'b1, 16'(i * 40), 32'h100 + 32'(i));

    // R5 drive the balance to its floor
    cur_req = "R5";
    rate_shift = 5'd0;
    burst_cap  = 31'd0;
    for (int i = 0; i < 33000; i++) step(1'b1, 16'hFFFF, 32'd7777);
    step(1'b1, 16'd0, 32'd7777);
    step(1'b1, 16'd0, 32'd7780);

    // R7 random traffic against the model
    cur_req = "R7";
    burst_cap = 31'd5000;
    t = 32'd20000;
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 15) == 0) rate_shift = 5'($urandom_range(0, 31));
      else if ($urandom_range(0, 7) == 0) rate_shift = 5'($urandom_range(0, 4));
      if ($urandom_range(0, 31) == 0) burst_cap = 31'($urandom());
      if ($urandom_range(0, 63) == 0) t = t + $urandom();
      else t = t + 32'($urandom_range(0, 20));
      step(($urandom_range(0, 9) < 7), 16'($urandom()), t);
    end
    step(1'b0, 16'd0, t);
    finish_run();
  end
endmodule